// File: doc/BRIEF.md
# Acquisition Trigger Unit

This block decides when a data acquisition starts. It watches three kinds of event and turns the first qualifying one into a single-cycle pulse on `trig_pulse` for the acquisition controller that sits downstream.

- **Level crossing.** One of four 16-bit sample streams, chosen by a channel select, is compared against a programmable threshold.
- **External edge.** A front-panel input is synchronised and edge-detected.
- **Software fire.** A one-cycle strobe requests a trigger directly.

The level-crossing and external paths together form the hardware source. A source-select field picks which of the two is live. A sense field picks the rising edge / upward slope or the falling edge / downward slope. The hardware source and the software strobe each have their own enable.

Every accepted event loads a release counter with the programmed delay. The counter counts sample strobes, and the pulse is issued when it runs out. While a release is pending, any further event is dropped. The configuration inputs are expected to come straight from register fields held elsewhere.

Top module: `acq_trigger_unit`

## Requirements
- R1: After reset, `trig_pulse` is low and no release is pending.
- R2: With the level source selected (`cfg_hw_src`=0), the hardware path enabled, rising sense (`cfg_falling`=0) and zero delay, a valid sample sets `trig_pulse` high for the cycle after its clock edge. This happens when the previous valid sample of the selected channel is below `cfg_threshold` and the current one is at or above it. Both comparisons are unsigned 16-bit.
- R3: With falling sense (`cfg_falling`=1), the level path fires when the previous valid sample is at or above the threshold and the current one is below it.
- R4: `cfg_chan_sel` value k (0..3) routes `smp_data[k]`, which is bits 16k+15 down to 16k of the bus, to the comparator. Crossings on any other channel have no effect.
- R5: With `cfg_hw_src`=1, `ext_trig_in` passes through two flip-flops before edge detection. A rising edge (sense 0) or a falling edge (sense 1) on the input makes `trig_pulse` high after the third clock edge that follows the change. The opposite edge produces nothing. With `cfg_hw_src`=0, the external input is ignored.
- R6: When `cfg_hw_en`=0, no hardware event produces a pulse. When `cfg_sw_en`=0, `sw_fire` produces no pulse.
- R7: When `cfg_sw_en`=1 and zero delay apply, a one-cycle `sw_fire` makes `trig_pulse` high for exactly the cycle after that edge, whatever the hardware settings are.
- R8: A nonzero `cfg_delay` D postpones the pulse until D further clock edges with `smp_valid` high have passed after the edge that accepted the event. Edges without `smp_valid` do not count.
- R9: Events that arrive while a release is pending, including one in the cycle the pending pulse is released, are dropped. An event in the cycle after the pulse is accepted.
- R10: The first valid sample after reset has no predecessor and cannot cause a crossing. Samples presented without `smp_valid` are neither compared nor remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for all channels |
| smp_data | input | 64 | Four 16-bit samples, channel k in bits 16k+15:16k |
| ext_trig_in | input | 1 | Asynchronous front-panel trigger input |
| sw_fire | input | 1 | One-cycle software fire strobe |
| cfg_hw_src | input | 1 | Hardware source: 0 level crossing, 1 external input |
| cfg_falling | input | 1 | Sense: 0 rising/upward, 1 falling/downward |
| cfg_hw_en | input | 1 | Hardware path enable |
| cfg_sw_en | input | 1 | Software path enable |
| cfg_chan_sel | input | 2 | Channel feeding the level comparator |
| cfg_threshold | input | 16 | Unsigned crossing threshold |
| cfg_delay | input | 32 | Release delay in sample strobes |
| trig_pulse | output | 1 | Single-cycle trigger output |

## Verification
Several thresholds are tried: zero, one, the two values around mid-scale, and full scale. For each one, every ordered pair of neighbouring sample values (below, at and above the threshold, plus the rails) is swept under both senses. This separates the strict-below comparison from the at-or-above comparison, and also exposes wrap-around and signed-compare faults.

In the channel sweep, the selected channel crosses one way while all the others cross the opposite way, so any mis-routing shows up as a pulse of the wrong kind.

The external path is driven with both edges under both senses. The pulse is checked on the exact cycle, which exposes a missing or extra synchroniser stage.

The delay is exercised with continuous strobes and with gapped strobes, and with events repeated before, on and just after the release cycle. This separates strobe counting from clock counting and shows exactly where the busy window ends.

// File: rtl/acqtrg_pkg.sv
// Shared encodings for the acquisition trigger unit.
// Assumes: nothing beyond IEEE 1800-2017.
package acqtrg_pkg;

    // Which hardware event drives the hardware path.
    typedef enum logic {
        HW_SRC_LEVEL = 1'b0,
        HW_SRC_EXT   = 1'b1
    } hw_src_e;

    // Direction of the edge or slope that qualifies.
    typedef enum logic {
        SENSE_RISE = 1'b0,
        SENSE_FALL = 1'b1
    } sense_e;

endpackage

// File: rtl/acqtrg_edge_sync.sv
// Synchroniser and edge detector for an asynchronous trigger input.
// What it does: the input passes through SYNC_STAGES flops, one more flop
// keeps the previous synchronised value, and evt flags the edge picked by
// 'falling' for the cycle in which the edge is seen.
// Assumes: async_in stays stable for at least one clock period per level.
module acqtrg_edge_sync
    import acqtrg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic falling,
    output logic evt
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;
    logic              cur_lvl;
    logic              old_lvl;

    // Shift the input through the synchroniser and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], async_in};
        end
    end

    assign cur_lvl = pipe_q[SYNC_STAGES-1];
    assign old_lvl = pipe_q[SYNC_STAGES];

    // Flag the edge that matches the programmed sense.
    always_comb begin
        if (sense_e'(falling) == SENSE_FALL) begin
            evt = old_lvl & ~cur_lvl;
        end else begin
            evt = cur_lvl & ~old_lvl;
        end
    end

    // Two edges of the same sense need the level to change twice.
    AST_NO_REPEAT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R5

endmodule

// File: rtl/acqtrg_level_cross.sv
// Threshold crossing detector on one of several sample channels.
// What it does: remembers the last valid sample of every channel and
// flags, on a valid sample, the crossing of the threshold in the
// programmed direction on the selected channel. Compares are unsigned.
// Assumes: NUM_CH is a power of two, so every select value is a channel;
// all channels share one valid strobe.
module acqtrg_level_cross
    import acqtrg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SMP_W  = 16,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [NUM_CH-1:0][SMP_W-1:0] smp_data,
    input  logic [SEL_W-1:0]             ch_sel,
    input  logic [SMP_W-1:0]             threshold,
    input  logic                         falling,
    output logic                         evt
);

    logic [SMP_W-1:0] prev_q [NUM_CH];
    logic             have_prev_q;
    logic [SMP_W-1:0] cur_smp;
    logic [SMP_W-1:0] old_smp;
    logic             cur_below;
    logic             old_below;
    logic             up_cross;
    logic             dn_cross;

    // One history register per channel so a select change sees fresh data.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_hist
        // Capture the channel's sample on every valid strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= '0;
            end else if (smp_valid) begin
                prev_q[g] <= smp_data[g];
            end
        end
    end

    // Remember that at least one valid sample has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
        end else if (smp_valid) begin
            have_prev_q <= 1'b1;
        end
    end

    // Compare old and new sample of the selected channel with the threshold.
    always_comb begin
        cur_smp   = smp_data[ch_sel];
        old_smp   = prev_q[ch_sel];
        cur_below = cur_smp < threshold;
        old_below = old_smp < threshold;
        up_cross  = old_below & ~cur_below;
        dn_cross  = ~old_below & cur_below;
        if (sense_e'(falling) == SENSE_FALL) begin
            evt = smp_valid & have_prev_q & dn_cross;
        end else begin
            evt = smp_valid & have_prev_q & up_cross;
        end
    end

    // A sample strobe always leaves a usable predecessor behind.
    AST_HIST_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> have_prev_q); // R10

endmodule

// File: rtl/acqtrg_release.sv
// Delayed-release counter for accepted trigger events.
// What it does: an event seen while idle either fires at once (zero delay)
// or loads the counter; each valid strobe then counts down and the pulse
// leaves when the last strobe is counted. Events while busy are dropped.
// Assumes: 'delay' is sampled only when an event is accepted.
module acqtrg_release #(
    parameter int DLY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             smp_valid,
    input  logic [DLY_W-1:0] delay,
    output logic             pulse,
    output logic             pending
);

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] cnt_q;
    logic             pend_q;
    logic             pulse_q;
    logic             accept;
    logic             last_tick;

    // Decode acceptance of a new event and the final counted strobe.
    always_comb begin
        accept    = evt & ~pend_q;
        last_tick = pend_q & smp_valid & (cnt_q == ONE);
    end

    // Load, count down and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (accept & (delay == '0)) | last_tick;
            if (accept && (delay != '0)) begin
                cnt_q  <= delay;
                pend_q <= 1'b1;
            end else if (pend_q && smp_valid) begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == ONE) begin
                    pend_q <= 1'b0;
                end
            end
        end
    end

    assign pulse   = pulse_q;
    assign pending = pend_q;

    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (cnt_q != '0)); // R8
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !smp_valid) |=> (pend_q && $stable(cnt_q))); // R8
    AST_LOAD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !pend_q && (delay != '0)) |=> (pend_q && cnt_q == $past(delay))); // R8
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(smp_valid && cnt_q == ONE)) |=> !pulse_q); // R9

endmodule

// File: rtl/acq_trigger_unit.sv
// Acquisition trigger unit: merges a level-crossing detector, an external
// edge detector and a software strobe into one delayed trigger pulse.
// What it does: the hardware path takes either detector per cfg_hw_src,
// gated by cfg_hw_en; the software path is sw_fire gated by cfg_sw_en;
// either event feeds the release counter that drives trig_pulse.
// Assumes: configuration is quasi-static while a release is pending.
module acq_trigger_unit
    import acqtrg_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SMP_W       = 16,
    parameter int DLY_W       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [NUM_CH-1:0][SMP_W-1:0] smp_data,
    input  logic                         ext_trig_in,
    input  logic                         sw_fire,
    input  logic                         cfg_hw_src,
    input  logic                         cfg_falling,
    input  logic                         cfg_hw_en,
    input  logic                         cfg_sw_en,
    input  logic [SEL_W-1:0]             cfg_chan_sel,
    input  logic [SMP_W-1:0]             cfg_threshold,
    input  logic [DLY_W-1:0]             cfg_delay,
    output logic                         trig_pulse
);

    logic lvl_evt;
    logic ext_evt;
    logic hw_evt;
    logic sw_evt;
    logic any_evt;
    logic dly_pending;

    acqtrg_level_cross #(
        .NUM_CH (NUM_CH),
        .SMP_W  (SMP_W)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .ch_sel    (cfg_chan_sel),
        .threshold (cfg_threshold),
        .falling   (cfg_falling),
        .evt       (lvl_evt)
    );

    acqtrg_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig_in),
        .falling  (cfg_falling),
        .evt      (ext_evt)
    );

    // Select and gate the hardware and software events.
    always_comb begin
        if (hw_src_e'(cfg_hw_src) == HW_SRC_EXT) begin
            hw_evt = cfg_hw_en & ext_evt;
        end else begin
            hw_evt = cfg_hw_en & lvl_evt;
        end
        sw_evt  = cfg_sw_en & sw_fire;
        any_evt = hw_evt | sw_evt;
    end

    acqtrg_release #(
        .DLY_W (DLY_W)
    ) u_release (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (any_evt),
        .smp_valid (smp_valid),
        .delay     (cfg_delay),
        .pulse     (trig_pulse),
        .pending   (dly_pending)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hw_en && !cfg_sw_en && !dly_pending) |=> !trig_pulse); // R6
    AST_SW_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sw_en && sw_fire && !dly_pending && cfg_delay == '0) |=> trig_pulse); // R7

endmodule

// File: tb/acq_trigger_unit_tb.sv
module acq_trigger_unit_tb;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             smp_valid;
    logic [3:0][15:0] smp_data;
    logic             ext_trig_in;
    logic             sw_fire;
    logic             cfg_hw_src;
    logic             cfg_falling;
    logic             cfg_hw_en;
    logic             cfg_sw_en;
    logic [1:0]       cfg_chan_sel;
    logic [15:0]      cfg_threshold;
    logic [31:0]      cfg_delay;
    logic             trig_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference history of the sample streams.
    logic [15:0] m_prev [4];
    bit          m_ok;

    always #10 clk = ~clk;

    acq_trigger_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .ext_trig_in   (ext_trig_in),
        .sw_fire       (sw_fire),
        .cfg_hw_src    (cfg_hw_src),
        .cfg_falling   (cfg_falling),
        .cfg_hw_en     (cfg_hw_en),
        .cfg_sw_en     (cfg_sw_en),
        .cfg_chan_sel  (cfg_chan_sel),
        .cfg_threshold (cfg_threshold),
        .cfg_delay     (cfg_delay),
        .trig_pulse    (trig_pulse)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit exp, input string req);
        n_chk++;
        if (trig_pulse !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_pulse got %0b expected %0b at %0t", req, trig_pulse, exp, $time);
        end
    endtask

    function automatic bit crossed(input bit fall, input logic [15:0] p,
                                   input logic [15:0] c, input logic [15:0] t);
        if (fall) return (p >= t) && (c < t);
        return (p < t) && (c >= t);
    endfunction

    // Present one sample word; the expected pulse is computed from the model.
    task automatic push(input logic [3:0][15:0] d, input bit v, input string req);
        bit exp;
        exp = v && m_ok && cfg_hw_en && !cfg_hw_src &&
              crossed(cfg_falling, m_prev[cfg_chan_sel], d[cfg_chan_sel], cfg_threshold);
        smp_data  = d;
        smp_valid = v;
        tick();
        check(exp, req);
        if (v) begin
            for (int k = 0; k < 4; k++) m_prev[k] = d[k];
            m_ok = 1'b1;
        end
        smp_valid = 1'b0;
    endtask

    function automatic logic [3:0][15:0] all4(input logic [15:0] x);
        return {x, x, x, x};
    endfunction

    // Drive one level on the external input and expect a pulse on tick 3 only.
    task automatic ext_level(input bit lvl, input bit exp, input string req);
        ext_trig_in = lvl;
        for (int i = 1; i <= 5; i++) begin
            tick();
            check(exp && (i == 3), req);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] thr_list [5];
        logic [15:0] vals [5];
        rst_n         = 1'b0;
        smp_valid     = 1'b0;
        smp_data      = '0;
        ext_trig_in   = 1'b0;
        sw_fire       = 1'b0;
        cfg_hw_src    = 1'b0;
        cfg_falling   = 1'b0;
        cfg_hw_en     = 1'b1;
        cfg_sw_en     = 1'b0;
        cfg_chan_sel  = 2'd0;
        cfg_threshold = 16'd100;
        cfg_delay     = 32'd0;
        m_ok          = 1'b0;
        for (int k = 0; k < 4; k++) m_prev[k] = '0;
        repeat (3) tick();
        rst_n = 1'b1;

        // R1: quiet after reset
        for (int i = 0; i < 3; i++) begin
            tick();
            check(1'b0, "R1 reset state");
        end

        // R10: first sample has no predecessor; invalid samples are ignored
        push(all4(16'd200), 1'b1, "R10 first sample");
        push(all4(16'd50),  1'b0, "R10 invalid sample");
        push(all4(16'd200), 1'b1, "R10 invalid not remembered");
        push(all4(16'd50),  1'b1, "R10 setup");
        push(all4(16'd200), 1'b1, "R10 normal crossing after");

        // R2 / R3: threshold x sample-pair sweep, both senses
        thr_list = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        for (int pol = 0; pol < 2; pol++) begin
            cfg_falling = pol[0];
            for (int ti = 0; ti < 5; ti++) begin
                cfg_threshold = thr_list[ti];
                vals = '{16'h0000, thr_list[ti] - 16'd1, thr_list[ti],
                         thr_list[ti] + 16'd1, 16'hFFFF};
                for (int a = 0; a < 5; a++) begin
                    for (int b = 0; b < 5; b++) begin
                        push(all4(vals[a]), 1'b1, pol ? "R3 setup" : "R2 setup");
                        push(all4(vals[b]), 1'b1, pol ? "R3 falling crossing" : "R2 rising crossing");
                    end
                end
            end
        end

        // R4: selected channel crosses one way, all others the opposite way
        cfg_threshold = 16'd100;
        for (int pol = 0; pol < 2; pol++) begin
            cfg_falling = pol[0];
            for (int sel = 0; sel < 4; sel++) begin
                logic [3:0][15:0] d1;
                logic [3:0][15:0] d2;
                cfg_chan_sel = sel[1:0];
                for (int k = 0; k < 4; k++) begin
                    d1[k] = ((k == sel) != (pol == 1)) ? 16'd50 : 16'd150;
                    d2[k] = ((k == sel) != (pol == 1)) ? 16'd150 : 16'd50;
                end
                push(d1, 1'b1, "R4 setup");
                push(d2, 1'b1, "R4 channel select");
                push(d1, 1'b1, "R4 channel select back");
            end
        end

        // R6: hardware path disabled
        cfg_chan_sel = 2'd0;
        cfg_falling  = 1'b0;
        cfg_hw_en    = 1'b0;
        push(all4(16'd10),  1'b1, "R6 setup");
        push(all4(16'd500), 1'b1, "R6 hw disabled crossing");
        cfg_hw_en = 1'b1;

        // R5: external input edges under both senses
        cfg_hw_src = 1'b1;
        cfg_falling = 1'b0;
        ext_level(1'b1, 1'b1, "R5 rising edge sense0");
        ext_level(1'b0, 1'b0, "R5 falling edge sense0");
        cfg_falling = 1'b1;
        ext_level(1'b1, 1'b0, "R5 rising edge sense1");
        ext_level(1'b0, 1'b1, "R5 falling edge sense1");
        cfg_hw_en = 1'b0;
        ext_level(1'b1, 1'b0, "R6 ext hw disabled");
        ext_level(1'b0, 1'b0, "R6 ext hw disabled");
        cfg_hw_en  = 1'b1;
        cfg_hw_src = 1'b0;
        cfg_falling = 1'b0;
        ext_level(1'b1, 1'b0, "R5 ext ignored with level source");
        ext_level(1'b0, 1'b0, "R5 ext ignored with level source");

        // R6: software strobe with software path disabled
        cfg_sw_en = 1'b0;
        sw_fire = 1'b1;
        tick();
        sw_fire = 1'b0;
        check(1'b0, "R6 sw disabled");
        tick();
        check(1'b0, "R6 sw disabled");

        // R7: software strobe, immediate
        cfg_sw_en = 1'b1;
        cfg_hw_en = 1'b0;
        for (int r = 0; r < 2; r++) begin
            cfg_hw_src = r[0];
            sw_fire = 1'b1;
            tick();
            sw_fire = 1'b0;
            check(1'b1, "R7 sw fire");
            tick();
            check(1'b0, "R7 single cycle");
        end
        cfg_hw_src = 1'b0;

        // R8: delay with continuous strobes
        smp_data  = all4(16'd0);
        smp_valid = 1'b1;
        for (int di = 1; di <= 8; di++) begin
            cfg_delay = 32'(di);
            sw_fire = 1'b1;
            tick();
            sw_fire = 1'b0;
            check(1'b0, "R8 not immediate");
            for (int i = 1; i <= di + 1; i++) begin
                tick();
                check(i == di, "R8 continuous delay");
            end
        end

        // R8: delay counts strobes, not clocks
        cfg_delay = 32'd3;
        smp_valid = 1'b0;
        sw_fire = 1'b1;
        tick();
        sw_fire = 1'b0;
        check(1'b0, "R8 gapped event");
        begin
            int c;
            c = 0;
            for (int i = 1; i <= 8; i++) begin
                smp_valid = i[0];
                if (smp_valid) c++;
                tick();
                check(smp_valid && (c == 3), "R8 gapped delay");
            end
        end

        // R9: events during pending are dropped, next one accepted
        cfg_delay = 32'd4;
        smp_valid = 1'b1;
        sw_fire = 1'b1;
        tick();
        sw_fire = 1'b0;
        check(1'b0, "R9 first event");
        for (int i = 1; i <= 10; i++) begin
            sw_fire = (i == 2) || (i == 4) || (i == 5);
            tick();
            check((i == 4) || (i == 9), "R9 busy window");
        end
        sw_fire = 1'b0;
        smp_valid = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule